// File: doc/BRIEF.md
# Double-Buffered Burst Store Queue

This block sits between a processor's store port and an external memory write bus. It holds two 32-byte line buffers that work as a ping-pong pair. The processor fills a buffer with ordinary longword stores into a reserved address window. It then issues a flush command that names the buffer and the external destination. The buffer is emptied as one burst of four 64-bit beats on a valid/ready write master. Meanwhile the processor keeps filling the other buffer without waiting.

The external master carries only one burst at a time. A buffer that has been flushed stays busy from the flush until its final beat is accepted. While it is busy, stores aimed at it are held off, so its contents stay frozen during the transfer. A second flush to a busy buffer is remembered and runs once the current burst is over. When both buffers wait for the bus, they take turns.

Top module: `sq_burst_pair`

## Requirements
- R1: After reset, both busy flags are 0, `m_valid` is 0, and both the store and the flush port report ready.
- R2: A store whose address lies in [0xE0000000, 0xE4000000) writes buffer `addr[5]`, longword slot `addr[4:2]`. No other address bit matters. A store outside that window is accepted and changes nothing.
- R3: Byte enable bit k of a store updates data bits 8k+7:8k of the slot and leaves the other bytes of that slot unchanged.
- R4: An accepted flush sets the busy flag of `cpu_fl_sel` from the next cycle. The destination address is used with its low five bits forced to zero.
- R5: A burst is four beats at addresses base, base+8, base+16 and base+24. Beat n carries slot 2n+1 in bits 63:32 and slot 2n in bits 31:0. `m_last` is high on the fourth beat only.
- R6: While `m_valid` is high and `m_ready` is low, the address, data and last outputs hold steady.
- R7: A store to a buffer that is not busy is accepted in the same cycle (`cpu_wr_ready` high), even while the other buffer is draining.
- R8: A store to a busy buffer is held with `cpu_wr_ready` low until the busy flag clears. A busy buffer's contents do not change.
- R9: A buffer's busy flag goes low in the cycle after its fourth beat is accepted, unless a further flush of that buffer is pending.
- R10: A flush of a busy buffer with nothing pending is accepted and later produces a second burst of the same contents to its own address. While a flush is pending, `cpu_fl_ready` is low for that buffer.
- R11: When both buffers wait for the bus, the one not served most recently goes first. Buffer 0 goes first after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_wr_en | input | 1 | Store request |
| cpu_wr_addr | input | 32 | Store address |
| cpu_wr_data | input | 32 | Store data |
| cpu_wr_be | input | 4 | Store byte enables |
| cpu_wr_ready | output | 1 | Store accepted when high with `cpu_wr_en` |
| cpu_fl_en | input | 1 | Flush request |
| cpu_fl_sel | input | 1 | Buffer to flush |
| cpu_fl_addr | input | 32 | External destination of the flush |
| cpu_fl_ready | output | 1 | Flush accepted when high with `cpu_fl_en` |
| m_valid | output | 1 | Burst beat valid |
| m_ready | input | 1 | Burst beat accepted by memory |
| m_addr | output | 32 | Beat address |
| m_data | output | 64 | Beat data |
| m_last | output | 1 | Final beat of the burst |
| busy | output | 2 | Per-buffer busy flag |

## Verification
The properties assume that the memory side never withdraws `m_ready` in a way that matters to them. They also assume that a requester drops a store or flush only by deasserting its enable, never by changing the address while waiting. The bench keeps to this. It holds each request steady until it sees the matching ready, and it abandons a stalled store only by lowering the enable. Every flush goes to a distinct destination, so each observed burst can be matched to its expected contents by address. Random ready patterns on the memory side stretch the bursts so that fills of the other buffer and pending flushes overlap them.

// File: rtl/sqb_pkg.sv
package sqb_pkg;
    // Ping-pong pair: the count of buffers is fixed by the scheme.
    localparam int NQ     = 2;
    localparam int QSEL_W = 1;
    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int BE_W   = WORD_W / BYTE_W;
endpackage

// File: rtl/sqb_store.sv
module sqb_store
    import sqb_pkg::*;
#(
    parameter int SLOTS = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_go,
    input  logic [$clog2(SLOTS)-1:0]  wr_slot,
    input  logic [BE_W-1:0]           wr_be,
    input  logic [WORD_W-1:0]         wr_data,
    output logic [SLOTS*WORD_W-1:0]   line
);
    typedef struct packed {
        logic [SLOTS-1:0][WORD_W-1:0] w;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_go) begin
            for (int b = 0; b < BE_W; b++) begin
                if (wr_be[b]) begin
                    st_d.w[wr_slot][b*BYTE_W +: BYTE_W] = wr_data[b*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line = st_q.w;
endmodule

// File: rtl/sqb_ctrl.sv
module sqb_ctrl
    import sqb_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fl_go,
    input  logic [QSEL_W-1:0]      fl_sel,
    input  logic [AW-1:0]          fl_addr,
    input  logic [NQ-1:0]          done,
    output logic [NQ-1:0]          busy,
    output logic [NQ-1:0]          pend,
    output logic [NQ-1:0][AW-1:0]  base
);
    localparam logic [AW-1:0] OFF_MASK = AW'(LINE_BYTES - 1);

    typedef struct packed {
        logic [NQ-1:0]         busy;
        logic [NQ-1:0]         pend;
        logic [NQ-1:0][AW-1:0] base;
        logic [NQ-1:0][AW-1:0] pbase;
    } ctl_t;

    ctl_t          c_d, c_q;
    logic [AW-1:0] aligned;

    assign aligned = fl_addr & ~OFF_MASK;

    always_comb begin
        c_d = c_q;
        // Completion first: a pending flush takes over the buffer.
        for (int i = 0; i < NQ; i++) begin
            if (done[i]) begin
                if (c_q.pend[i]) begin
                    c_d.base[i] = c_q.pbase[i];
                    c_d.pend[i] = 1'b0;
                end else begin
                    c_d.busy[i] = 1'b0;
                end
            end
        end
        // New flush sees the buffer state after completion.
        if (fl_go) begin
            if (c_d.busy[fl_sel]) begin
                c_d.pend[fl_sel]  = 1'b1;
                c_d.pbase[fl_sel] = aligned;
            end else begin
                c_d.busy[fl_sel] = 1'b1;
                c_d.base[fl_sel] = aligned;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign busy = c_q.busy;
    assign pend = c_q.pend;
    assign base = c_q.base;
endmodule

// File: rtl/sqb_drain.sv
module sqb_drain
    import sqb_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 32,
    parameter int BUS_W      = 64
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NQ-1:0]                        busy,
    input  logic [NQ-1:0][AW-1:0]                base,
    input  logic [NQ-1:0][LINE_BYTES*8-1:0]      lines,
    input  logic                                 m_ready,
    output logic                                 m_valid,
    output logic [AW-1:0]                        m_addr,
    output logic [BUS_W-1:0]                     m_data,
    output logic                                 m_last,
    output logic [NQ-1:0]                        done
);
    localparam int BEATS      = (LINE_BYTES * 8) / BUS_W;
    localparam int BEAT_W     = $clog2(BEATS);
    localparam int BEAT_BYTES = BUS_W / 8;
    localparam int BOFF_W     = $clog2(BEAT_BYTES);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    typedef struct packed {
        logic              act;
        logic [QSEL_W-1:0] cq;
        logic [QSEL_W-1:0] prev;
        logic [BEAT_W-1:0] beat;
        logic [AW-1:0]     base;
    } drain_t;

    drain_t            d_d, d_q;
    logic              found;
    logic [QSEL_W-1:0] pick;
    logic [QSEL_W-1:0] idx;

    // Rotating choice starting after the buffer served last.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        idx   = '0;
        for (int k = 1; k <= NQ; k++) begin
            idx = QSEL_W'((int'(d_q.prev) + k) % NQ);
            if (!found && busy[idx]) begin
                found = 1'b1;
                pick  = idx;
            end
        end
    end

    always_comb begin
        d_d  = d_q;
        done = '0;
        if (d_q.act) begin
            if (m_ready) begin
                if (d_q.beat == LAST_BEAT) begin
                    d_d.act        = 1'b0;
                    d_d.prev       = d_q.cq;
                    done[d_q.cq]   = 1'b1;
                end else begin
                    d_d.beat = d_q.beat + 1'b1;
                end
            end
        end else if (found) begin
            d_d.act  = 1'b1;
            d_d.cq   = pick;
            d_d.beat = '0;
            d_d.base = base[pick];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q      <= '0;
            d_q.prev <= QSEL_W'(NQ - 1);
        end else begin
            d_q <= d_d;
        end
    end

    assign m_valid = d_q.act;
    assign m_addr  = d_q.base + (AW'(d_q.beat) << BOFF_W);
    assign m_data  = lines[d_q.cq][int'(d_q.beat)*BUS_W +: BUS_W];
    assign m_last  = d_q.act && (d_q.beat == LAST_BEAT);
endmodule

// File: rtl/sq_burst_pair.sv
module sq_burst_pair
    import sqb_pkg::*;
#(
    parameter int              AW         = 32,
    parameter int              LINE_BYTES = 32,
    parameter int              BUS_W      = 64,
    parameter logic [AW-1:0]   WIN_LO     = 32'hE000_0000,
    parameter logic [AW-1:0]   WIN_HI     = 32'hE400_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_wr_en,
    input  logic [AW-1:0]      cpu_wr_addr,
    input  logic [WORD_W-1:0]  cpu_wr_data,
    input  logic [BE_W-1:0]    cpu_wr_be,
    output logic               cpu_wr_ready,
    input  logic               cpu_fl_en,
    input  logic [QSEL_W-1:0]  cpu_fl_sel,
    input  logic [AW-1:0]      cpu_fl_addr,
    output logic               cpu_fl_ready,
    output logic               m_valid,
    input  logic               m_ready,
    output logic [AW-1:0]      m_addr,
    output logic [BUS_W-1:0]   m_data,
    output logic               m_last,
    output logic [NQ-1:0]      busy
);
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int SLOTS  = LINE_W / WORD_W;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int LSB    = $clog2(BE_W);

    logic                        in_win;
    logic [QSEL_W-1:0]           wr_q;
    logic [SLOT_W-1:0]           wr_slot;
    logic                        wr_go;
    logic                        fl_go;
    logic [NQ-1:0]               busy_w;
    logic [NQ-1:0]               pend_w;
    logic [NQ-1:0]               done_w;
    logic [NQ-1:0][AW-1:0]       base_w;
    logic [NQ-1:0][LINE_W-1:0]   lines_w;

    // Window decode and store steering.
    assign in_win       = (cpu_wr_addr >= WIN_LO) && (cpu_wr_addr < WIN_HI);
    assign wr_q         = cpu_wr_addr[OFF_W +: QSEL_W];
    assign wr_slot      = cpu_wr_addr[LSB +: SLOT_W];
    assign cpu_wr_ready = !in_win || !busy_w[wr_q];
    assign wr_go        = cpu_wr_en && in_win && !busy_w[wr_q];

    assign cpu_fl_ready = !pend_w[cpu_fl_sel];
    assign fl_go        = cpu_fl_en && !pend_w[cpu_fl_sel];

    for (genvar g = 0; g < NQ; g++) begin : g_buf
        sqb_store #(
            .SLOTS (SLOTS)
        ) u_store (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_go   (wr_go && (wr_q == QSEL_W'(g))),
            .wr_slot (wr_slot),
            .wr_be   (cpu_wr_be),
            .wr_data (cpu_wr_data),
            .line    (lines_w[g])
        );
    end

    sqb_ctrl #(
        .AW         (AW),
        .LINE_BYTES (LINE_BYTES)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .fl_go   (fl_go),
        .fl_sel  (cpu_fl_sel),
        .fl_addr (cpu_fl_addr),
        .done    (done_w),
        .busy    (busy_w),
        .pend    (pend_w),
        .base    (base_w)
    );

    sqb_drain #(
        .AW         (AW),
        .LINE_BYTES (LINE_BYTES),
        .BUS_W      (BUS_W)
    ) u_drain (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy_w),
        .base    (base_w),
        .lines   (lines_w),
        .m_ready (m_ready),
        .m_valid (m_valid),
        .m_addr  (m_addr),
        .m_data  (m_data),
        .m_last  (m_last),
        .done    (done_w)
    );

    assign busy = busy_w;
endmodule

// File: rtl/sqb_chk.sv
module sqb_chk
    import sqb_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 32,
    parameter int BUS_W      = 64
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                cpu_fl_en,
    input logic                                cpu_fl_ready,
    input logic [QSEL_W-1:0]                   cpu_fl_sel,
    input logic                                m_valid,
    input logic                                m_ready,
    input logic                                m_last,
    input logic [AW-1:0]                       m_addr,
    input logic [BUS_W-1:0]                    m_data,
    input logic [NQ-1:0]                       busy,
    input logic [NQ-1:0]                       pend,
    input logic [NQ-1:0][LINE_BYTES*8-1:0]     lines
);
    localparam int BEATS  = (LINE_BYTES * 8) / BUS_W;
    localparam int BEAT_W = $clog2(BEATS);

    logic [BEAT_W-1:0] hs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q <= '0;
        end else if (m_valid && m_ready) begin
            hs_q <= m_last ? '0 : hs_q + 1'b1;
        end
    end

    assert_flush_sets_busy0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_fl_en && cpu_fl_ready && cpu_fl_sel == 1'b0) |=> busy[0]);
    assert_flush_sets_busy1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_fl_en && cpu_fl_ready && cpu_fl_sel == 1'b1) |=> busy[1]);

    assert_last_on_fourth_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready) |-> (m_last == (hs_q == BEAT_W'(BEATS - 1))));
    assert_valid_needs_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (busy != '0));

    assert_beat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_data) && $stable(m_last)));

    assert_line0_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy[0] |=> $stable(lines[0]));
    assert_line1_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy[1] |=> $stable(lines[1]));

    assert_busy0_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy[0]) |-> $past(m_valid && m_ready && m_last));
    assert_busy1_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy[1]) |-> $past(m_valid && m_ready && m_last));

    assert_pend_needs_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & ~busy) == '0);
endmodule

bind sq_burst_pair sqb_chk #(
    .AW         (AW),
    .LINE_BYTES (LINE_BYTES),
    .BUS_W      (BUS_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_fl_en    (cpu_fl_en),
    .cpu_fl_ready (cpu_fl_ready),
    .cpu_fl_sel   (cpu_fl_sel),
    .m_valid      (m_valid),
    .m_ready      (m_ready),
    .m_last       (m_last),
    .m_addr       (m_addr),
    .m_data       (m_data),
    .busy         (busy),
    .pend         (pend_w),
    .lines        (lines_w)
);

// File: tb/sim_sq_burst_pair.sv
`timescale 1ns/1ps
module sim_sq_burst_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr_en = 1'b0;
    logic [31:0] cpu_wr_addr = '0;
    logic [31:0] cpu_wr_data = '0;
    logic [3:0]  cpu_wr_be = '0;
    logic        cpu_wr_ready;
    logic        cpu_fl_en = 1'b0;
    logic        cpu_fl_sel = 1'b0;
    logic [31:0] cpu_fl_addr = '0;
    logic        cpu_fl_ready;
    logic        m_valid;
    logic        m_ready = 1'b0;
    logic [31:0] m_addr;
    logic [63:0] m_data;
    logic        m_last;
    logic [1:0]  busy;

    always #2.5 clk = ~clk;

    sq_burst_pair u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_wr_en(cpu_wr_en), .cpu_wr_addr(cpu_wr_addr), .cpu_wr_data(cpu_wr_data),
        .cpu_wr_be(cpu_wr_be), .cpu_wr_ready(cpu_wr_ready),
        .cpu_fl_en(cpu_fl_en), .cpu_fl_sel(cpu_fl_sel), .cpu_fl_addr(cpu_fl_addr),
        .cpu_fl_ready(cpu_fl_ready),
        .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_data(m_data),
        .m_last(m_last), .busy(busy)
    );

    int n_chk = 0;
    int n_bad = 0;
    int sink_mode = 0;
    int flush_cnt = 0;
    logic [31:0] mdl [2][8];
    bit          e_used [64];
    int          e_q    [64];
    logic [31:0] e_base [64];
    logic [31:0] e_w    [64][8];
    int          log_q  [256];
    int          log_n = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit in_win(input logic [31:0] a);
        return (a >= 32'hE000_0000) && (a < 32'hE400_0000);
    endfunction

    function automatic int outstanding(input int q);
        int n = 0;
        for (int i = 0; i < 64; i++) if (e_used[i] && e_q[i] == q) n++;
        return n;
    endfunction

    function automatic int outstanding_all();
        return outstanding(0) + outstanding(1);
    endfunction

    // R2, R3: model store
    task automatic mdl_store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        if (in_win(a)) begin
            for (int b = 0; b < 4; b++)
                if (be[b]) mdl[a[5]][a[4:2]][b*8 +: 8] = d[b*8 +: 8];
        end
    endtask

    task automatic cpu_write(input logic [31:0] a, input logic [31:0] d,
                             input logic [3:0] be, output int waited);
        waited = 0;
        @(negedge clk);
        cpu_wr_en = 1'b1; cpu_wr_addr = a; cpu_wr_data = d; cpu_wr_be = be;
        #1;
        while (!cpu_wr_ready) begin
            waited++;
            @(negedge clk); #1;
        end
        @(posedge clk);
        #1 cpu_wr_en = 1'b0;
        mdl_store(a, d, be);
    endtask

    task automatic cpu_flush(input int q, input logic [4:0] low);
        logic [31:0] a;
        int slot;
        a = 32'h1000_0000 + (32'(flush_cnt) << 5) + 32'(low);
        flush_cnt++;
        @(negedge clk);
        cpu_fl_en = 1'b1; cpu_fl_sel = q[0]; cpu_fl_addr = a;
        #1;
        while (!cpu_fl_ready) begin
            @(negedge clk); #1;
        end
        @(posedge clk);
        #1 cpu_fl_en = 1'b0;
        slot = -1;
        for (int i = 0; i < 64; i++) if (!e_used[i] && slot < 0) slot = i;
        e_used[slot] = 1'b1; e_q[slot] = q; e_base[slot] = a & 32'hFFFF_FFE0;
        for (int s = 0; s < 8; s++) e_w[slot][s] = mdl[q][s];
        @(negedge clk); #1;
        chk(busy[q] == 1'b1, "R4", "busy after flush", 64'(busy), 64'(2'b1 << q));
    endtask

    task automatic wait_drain();
        int t = 0;
        while ((outstanding_all() != 0 || busy != 2'b00) && t < 4000) begin
            @(negedge clk); #1; t++;
        end
        chk(t < 4000, "R9", "drain completes", 64'(outstanding_all()), 64'd0);
    endtask

    // Memory-side sink and burst checker
    initial begin : sink
        int bi = 0;
        int cur = -1;
        bit hold_v = 1'b0;
        logic [31:0] h_addr;
        logic [63:0] h_data;
        logic h_last;
        bit bchk = 1'b0;
        int bq = 0;
        forever begin
            @(negedge clk);
            case (sink_mode)
                0: m_ready = 1'b0;
                1: m_ready = 1'b1;
                default: m_ready = (($urandom % 4) != 0);
            endcase
            #1;
            if (bchk) begin
                bchk = 1'b0;
                chk(busy[bq] == (outstanding(bq) > 0), "R9", "busy after last beat",
                    64'(busy[bq]), 64'(outstanding(bq) > 0));
            end
            if (hold_v && rst_n) begin
                chk(m_valid && m_addr == h_addr && m_data == h_data && m_last == h_last,
                    "R6", "beat held", m_data, h_data);
            end
            hold_v = m_valid && !m_ready;
            h_addr = m_addr; h_data = m_data; h_last = m_last;
            if (m_valid && m_ready && rst_n) begin
                if (bi == 0) begin
                    cur = -1;
                    for (int i = 0; i < 64; i++)
                        if (e_used[i] && e_base[i] == m_addr && cur < 0) cur = i;
                    chk(cur >= 0, "R5", "burst start address known", 64'(m_addr), 64'd0);
                end
                if (cur >= 0) begin
                    chk(m_addr == e_base[cur] + 32'(bi * 8) &&
                        m_data == {e_w[cur][2*bi+1], e_w[cur][2*bi]} &&
                        m_last == (bi == 3),
                        "R5", "beat content", m_data, {e_w[cur][2*bi+1], e_w[cur][2*bi]});
                end
                bi++;
                if (bi == 4) begin
                    bi = 0;
                    if (cur >= 0) begin
                        e_used[cur] = 1'b0;
                        bq = e_q[cur];
                        log_q[log_n] = bq;
                        log_n++;
                        bchk = 1'b1;
                    end
                end
            end
        end
    end

    initial begin : watchdog
        #(5.0 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int w;
        int s0;
        void'($urandom(32'd2718));
        for (int q = 0; q < 2; q++) for (int s = 0; s < 8; s++) mdl[q][s] = '0;
        for (int i = 0; i < 64; i++) e_used[i] = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1
        chk(busy == 2'b00 && !m_valid, "R1", "idle after reset", {busy, m_valid}, 64'd0);
        chk(cpu_wr_ready && cpu_fl_ready, "R1", "ports ready", {cpu_wr_ready, cpu_fl_ready}, 64'd3);

        // R2, R7: fill buffer 0, drain stalled by memory, fill buffer 1 meanwhile
        sink_mode = 0;
        for (int s = 0; s < 8; s++) cpu_write(32'hE000_0000 + 32'(s*4), 32'hA000_0000 + 32'(s), 4'hF, w);
        cpu_flush(0, 5'd0);
        for (int s = 0; s < 8; s++) begin
            cpu_write(32'hE000_0020 + 32'(s*4), 32'hB100_0000 + 32'(s), 4'hF, w);
            chk(w == 0 && busy[0], "R7", "store to idle buffer while other drains", 64'(w), 64'd0);
        end

        // R8: store to busy buffer 0 held
        @(negedge clk);
        cpu_wr_en = 1'b1; cpu_wr_addr = 32'hE000_000C; cpu_wr_data = 32'hDEAD_BEEF; cpu_wr_be = 4'hF;
        for (int c = 0; c < 3; c++) begin
            #1 chk(!cpu_wr_ready, "R8", "store to busy buffer stalls", 64'(cpu_wr_ready), 64'd0);
            @(negedge clk);
        end
        cpu_wr_en = 1'b0;

        // R10, R11: queue buffer 1, pend buffer 0, third flush refused
        s0 = log_n;
        cpu_flush(1, 5'd0);
        cpu_flush(0, 5'd0);
        @(negedge clk);
        cpu_fl_en = 1'b1; cpu_fl_sel = 1'b0; cpu_fl_addr = 32'h2000_0000;
        #1 chk(!cpu_fl_ready, "R10", "flush refused while pending", 64'(cpu_fl_ready), 64'd0);
        cpu_fl_en = 1'b0;
        chk(busy == 2'b11, "R10", "both buffers busy", 64'(busy), 64'd3);
        sink_mode = 1;
        wait_drain();
        chk(log_n == s0 + 3 && log_q[s0] == 0 && log_q[s0+1] == 1 && log_q[s0+2] == 0,
            "R11", "burst order", {32'(log_q[s0]), 16'(log_q[s0+1]), 16'(log_q[s0+2])},
            {32'd0, 16'd1, 16'd0});

        // R2 ignored stores, R3 byte enables, R4 alignment
        sink_mode = 2;
        cpu_write(32'hE400_0000, 32'h1111_1111, 4'hF, w);
        chk(w == 0, "R2", "store above window accepted", 64'(w), 64'd0);
        cpu_write(32'hDFFF_FFFC, 32'h2222_2222, 4'hF, w);
        cpu_write(32'hE3FF_FFC4, 32'h5566_7788, 4'b0101, w);
        cpu_write(32'hE123_4560, 32'hCAFE_F00D, 4'b1000, w);
        cpu_flush(0, 5'h1B);
        cpu_flush(1, 5'h07);
        wait_drain();

        // Random traffic
        for (int n = 0; n < 400; n++) begin
            int r;
            logic [31:0] a;
            r = $urandom % 10;
            if (r < 6) begin
                a = 32'hE000_0000 + ($urandom & 32'h03FF_FFC0) + 32'(($urandom % 2) << 5)
                    + 32'(($urandom % 8) << 2);
                if (($urandom % 8) == 0) a = (($urandom % 2) == 0) ? 32'hE400_0000 + 32'($urandom % 256)
                                                                    : 32'hDFFF_FF00;
                cpu_write(a, $urandom, 4'($urandom), w);
            end else begin
                cpu_flush(int'($urandom % 2), 5'($urandom));
            end
        end
        sink_mode = 1;
        wait_drain();
        chk(outstanding_all() == 0 && !m_valid, "R5", "all bursts seen", 64'(outstanding_all()), 64'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule